// File: doc/BRIEF.md
# Sequential Integer Divide Unit

This block computes the quotient or the remainder of two 32-bit integers, signed or unsigned, for the execute stage of a 32-bit RISC-V core. The core presents a dividend, a divisor and a 2-bit operation code together with a one-cycle start strobe. The unit samples all of them on that edge, so the inputs may change freely afterwards. It raises a one-cycle done strobe when the result is ready, and the result stays on its output until the next done.

Ordinary operands are reduced to unsigned magnitudes and worked through one quotient bit per clock, most significant bit first. A final cycle restores the signs: quotients truncate toward zero and a remainder carries the sign of the dividend. Two operand patterns are answered directly without iterating, with the values the architecture fixes for them. These are a zero divisor, and the most negative signed value divided by minus one. A parameter selects a restoring or a non-restoring iteration step. Both give identical results and timing.

Top module: `rv_div_seq`

## Requirements
- R1: Operation code 1 gives the unsigned quotient and code 3 the unsigned remainder; for example 0x80000000 / 2 = 0x40000000 and 0x12345678 remainder 0x10 = 0x00000008.
- R2: Operation code 0 gives the signed quotient, rounded toward zero; for example -2 / 2 = -1 and -7 / 2 = -3.
- R3: Operation code 2 gives the signed remainder, which is zero or has the sign of the dividend; for example -2 remainder 3 = -2 and 7 remainder -2 = 1.
- R4: A zero divisor with code 0 or 1 returns 0xFFFFFFFF.
- R5: A zero divisor with code 2 or 3 returns the dividend unchanged.
- R6: Signed 0x80000000 divided by 0xFFFFFFFF returns 0x80000000 for code 0 and 0x00000000 for code 2.
- R7: For the cases in R4, R5 and R6, done_o is high in the cycle right after the edge that accepts start_i, and busy_o stays low.
- R8: For every other operation, busy_o is high from the cycle after the accepting edge for WIDTH+1 cycles. done_o is high in the cycle after the (WIDTH+2)-th rising edge counted from, and including, the accepting edge, and busy_o is low in that cycle.
- R9: A start_i pulse while busy_o is high is ignored: it produces no done_o and does not change the result of the operation in progress.
- R10: done_o is high for one cycle per accepted operation, and result_o changes only in a cycle where done_o is high.
- R11: While the synchronous active-high reset is applied, done_o and busy_o are low and result_o is zero.
- R12: Dividend, divisor and operation code are sampled only on the accepting edge; changing them afterwards does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin an operation; accepted when busy_o is low |
| op_i | input | 2 | 0 signed quotient, 1 unsigned quotient, 2 signed remainder, 3 unsigned remainder |
| dividend_i | input | WIDTH | Dividend |
| divisor_i | input | WIDTH | Divisor |
| busy_o | output | 1 | Iteration in progress; starts are ignored |
| done_o | output | 1 | One-cycle strobe, result_o valid |
| result_o | output | WIDTH | Quotient or remainder, held until the next done |

## Verification
The hardest situation to create from the ports is a start strobe that arrives while an iteration is in progress. It must be dropped with no trace. The bench issues a normal division, then pulses start_i partway through the run with a zero divisor. If that pulse were wrongly accepted, it would produce an early special-case done. The scoreboard would then see a surplus done or a wrong value. Operand inputs are also scrambled in every cycle after acceptance, to show that only the sampled values count.

// File: rtl/rv_div_pkg.sv
package rv_div_pkg;

   typedef enum logic [1:0] {
      OP_QUO_S = 2'd0,
      OP_QUO_U = 2'd1,
      OP_REM_S = 2'd2,
      OP_REM_U = 2'd3
   } div_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIX  = 2'd2
   } div_state_e;

   function automatic logic op_is_signed(input logic [1:0] op);
      return ~op[0];
   endfunction

   function automatic logic op_is_rem(input logic [1:0] op);
      return op[1];
   endfunction

endpackage

// File: rtl/rv_div_prep.sv
module rv_div_prep #(
   parameter int WIDTH = 32
) (
   input  logic [1:0]       op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] mag_a_o,
   output logic [WIDTH-1:0] mag_b_o,
   output logic             neg_q_o,
   output logic             neg_r_o,
   output logic             special_o,
   output logic [WIDTH-1:0] special_val_o
);
   import rv_div_pkg::*;

   localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

   logic sgn, a_neg, b_neg, b_zero, ovf;

   always_comb begin
      sgn     = op_is_signed(op_i);
      a_neg   = sgn & a_i[WIDTH-1];
      b_neg   = sgn & b_i[WIDTH-1];
      mag_a_o = a_neg ? (~a_i + 1'b1) : a_i;
      mag_b_o = b_neg ? (~b_i + 1'b1) : b_i;
      neg_q_o = a_neg ^ b_neg;
      neg_r_o = a_neg;
      b_zero  = (b_i == '0);
      ovf     = sgn && (a_i == MOST_NEG) && (b_i == '1);
      special_o = b_zero | ovf;
      if (b_zero)
         special_val_o = op_is_rem(op_i) ? a_i : '1;
      else
         special_val_o = op_is_rem(op_i) ? '0 : MOST_NEG;
   end

endmodule

// File: rtl/rv_div_core.sv
module rv_div_core #(
   parameter int WIDTH        = 32,
   parameter bit NONRESTORING = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic             step_i,
   input  logic [WIDTH-1:0] mag_a_i,
   input  logic [WIDTH-1:0] mag_b_i,
   output logic [WIDTH-1:0] quo_o,
   output logic [WIDTH-1:0] rem_o
);

   localparam int PW = WIDTH + 2;

   logic [WIDTH-1:0] quo_q;
   logic [WIDTH-1:0] dvs_q;

   assign quo_o = quo_q;

   generate
      if (NONRESTORING) begin : g_nonrestoring
         logic [PW-1:0] part_q;
         logic [PW-1:0] shifted, nxt, fixed;

         always_comb begin
            shifted = {part_q[WIDTH:0], quo_q[WIDTH-1]};
            nxt     = part_q[PW-1] ? (shifted + {2'b00, dvs_q})
                                   : (shifted - {2'b00, dvs_q});
            fixed   = part_q[PW-1] ? (part_q + {2'b00, dvs_q}) : part_q;
         end

         assign rem_o = fixed[WIDTH-1:0];

         always_ff @(posedge clk) begin
            if (rst) begin
               part_q <= '0;
               quo_q  <= '0;
               dvs_q  <= '0;
            end else if (load_i) begin
               part_q <= '0;
               quo_q  <= mag_a_i;
               dvs_q  <= mag_b_i;
            end else if (step_i) begin
               part_q <= nxt;
               quo_q  <= {quo_q[WIDTH-2:0], ~nxt[PW-1]};
            end
         end
      end else begin : g_restoring
         logic [WIDTH-1:0] part_q;
         logic [WIDTH:0]   shifted, diff;

         always_comb begin
            shifted = {part_q, quo_q[WIDTH-1]};
            diff    = shifted - {1'b0, dvs_q};
         end

         assign rem_o = part_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               part_q <= '0;
               quo_q  <= '0;
               dvs_q  <= '0;
            end else if (load_i) begin
               part_q <= '0;
               quo_q  <= mag_a_i;
               dvs_q  <= mag_b_i;
            end else if (step_i) begin
               part_q <= diff[WIDTH] ? shifted[WIDTH-1:0] : diff[WIDTH-1:0];
               quo_q  <= {quo_q[WIDTH-2:0], ~diff[WIDTH]};
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rv_div_post.sv
module rv_div_post #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] quo_i,
   input  logic [WIDTH-1:0] rem_i,
   input  logic             neg_q_i,
   input  logic             neg_r_i,
   input  logic             want_rem_i,
   output logic [WIDTH-1:0] result_o
);
   logic [WIDTH-1:0] quo_s, rem_s;

   always_comb begin
      quo_s    = neg_q_i ? (~quo_i + 1'b1) : quo_i;
      rem_s    = neg_r_i ? (~rem_i + 1'b1) : rem_i;
      result_o = want_rem_i ? rem_s : quo_s;
   end

endmodule

// File: rtl/rv_div_seq.sv
module rv_div_seq #(
   parameter int WIDTH        = 32,
   parameter bit NONRESTORING = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_i,
   input  logic [1:0]       op_i,
   input  logic [WIDTH-1:0] dividend_i,
   input  logic [WIDTH-1:0] divisor_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [WIDTH-1:0] result_o
);
   import rv_div_pkg::*;

   localparam int CW = $clog2(WIDTH);
   localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

   initial begin
      assert (WIDTH >= 4) else $error("rv_div_seq: WIDTH must be at least 4");
   end

   div_state_e       state_q;
   logic [CW-1:0]    cnt_q;
   logic             neg_q_q, neg_r_q, rem_sel_q;
   logic             done_q;
   logic [WIDTH-1:0] res_q;

   logic [WIDTH-1:0] mag_a, mag_b, spec_val, quo, rem, fixed_res;
   logic             neg_q, neg_r, special;
   logic             accept, core_load, core_step;

   rv_div_prep #(.WIDTH(WIDTH)) u_prep (
      .op_i          (op_i),
      .a_i           (dividend_i),
      .b_i           (divisor_i),
      .mag_a_o       (mag_a),
      .mag_b_o       (mag_b),
      .neg_q_o       (neg_q),
      .neg_r_o       (neg_r),
      .special_o     (special),
      .special_val_o (spec_val)
   );

   assign accept    = start_i && (state_q == ST_IDLE);
   assign core_load = accept && !special;
   assign core_step = (state_q == ST_RUN);

   rv_div_core #(.WIDTH(WIDTH), .NONRESTORING(NONRESTORING)) u_core (
      .clk     (clk),
      .rst     (rst),
      .load_i  (core_load),
      .step_i  (core_step),
      .mag_a_i (mag_a),
      .mag_b_i (mag_b),
      .quo_o   (quo),
      .rem_o   (rem)
   );

   rv_div_post #(.WIDTH(WIDTH)) u_post (
      .quo_i      (quo),
      .rem_i      (rem),
      .neg_q_i    (neg_q_q),
      .neg_r_i    (neg_r_q),
      .want_rem_i (rem_sel_q),
      .result_o   (fixed_res)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         neg_q_q   <= 1'b0;
         neg_r_q   <= 1'b0;
         rem_sel_q <= 1'b0;
         done_q    <= 1'b0;
         res_q     <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  neg_q_q   <= neg_q;
                  neg_r_q   <= neg_r;
                  rem_sel_q <= op_is_rem(op_i);
                  if (special) begin
                     res_q  <= spec_val;
                     done_q <= 1'b1;
                  end else begin
                     cnt_q   <= '0;
                     state_q <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST_STEP) state_q <= ST_FIX;
            end
            ST_FIX: begin
               res_q   <= fixed_res;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o   = (state_q != ST_IDLE);
   assign done_o   = done_q;
   assign result_o = res_q;

endmodule

// File: rtl/rv_div_checker.sv
module rv_div_checker #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             start_i,
   input logic [1:0]       op_i,
   input logic [WIDTH-1:0] dividend_i,
   input logic [WIDTH-1:0] divisor_i,
   input logic             busy_o,
   input logic             done_o,
   input logic [WIDTH-1:0] result_o
);
   localparam int BW = $clog2(WIDTH + 2) + 1;
   localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

   logic [BW-1:0] busy_run;

   always_ff @(posedge clk) begin
      if (rst)         busy_run <= '0;
      else if (busy_o) busy_run <= busy_run + 1'b1;
      else             busy_run <= '0;
   end

   assert_zero_fast_R7: assert property (@(posedge clk) disable iff (rst)
      (start_i && !busy_o && divisor_i == '0) |=> (done_o && !busy_o));

   assert_zero_quo_R4: assert property (@(posedge clk) disable iff (rst)
      (start_i && !busy_o && divisor_i == '0 && !op_i[1]) |=> (result_o == '1));

   assert_zero_rem_R5: assert property (@(posedge clk) disable iff (rst)
      (start_i && !busy_o && divisor_i == '0 && op_i[1]) |=> (result_o == $past(dividend_i)));

   assert_ovf_value_R6: assert property (@(posedge clk) disable iff (rst)
      (start_i && !busy_o && !op_i[0] && dividend_i == MOST_NEG && divisor_i == '1)
      |=> (result_o == ($past(op_i[1]) ? '0 : MOST_NEG)));

   assert_run_length_R8: assert property (@(posedge clk) disable iff (rst)
      busy_o |-> (busy_run <= BW'(WIDTH)));

   assert_run_ends_done_R8: assert property (@(posedge clk) disable iff (rst)
      $fell(busy_o) |-> done_o);

   assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_o) |-> $past(start_i));

   assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !done_o |-> $stable(result_o));

   assert_no_done_busy_R10: assert property (@(posedge clk) disable iff (rst)
      busy_o |-> !done_o);

endmodule

bind rv_div_seq rv_div_checker #(.WIDTH(WIDTH)) u_rv_div_checker (
   .clk        (clk),
   .rst        (rst),
   .start_i    (start_i),
   .op_i       (op_i),
   .dividend_i (dividend_i),
   .divisor_i  (divisor_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .result_o   (result_o)
);

// File: tb/tb_rv_div_seq.sv
`timescale 1ns/1ps
module tb_rv_div_seq;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start_i = 1'b0;
   logic [1:0]   op_i = 2'd0;
   logic [W-1:0] dividend_i = '0;
   logic [W-1:0] divisor_i = '0;
   logic         busy_o, done_o;
   logic [W-1:0] result_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic [W-1:0] last_res = '0;

   logic [W-1:0] exp_q[$];
   int           lat_q[$];
   int           iss_q[$];
   string        req_q[$];

   rv_div_seq #(.WIDTH(W)) dut (
      .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
      .dividend_i(dividend_i), .divisor_i(divisor_i),
      .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   function automatic bit is_special(input logic [W-1:0] a, input logic [W-1:0] b,
                                     input logic [1:0] op);
      return (b == 0) || (op[0] == 1'b0 && a == 32'h8000_0000 && b == 32'hFFFF_FFFF);
   endfunction

   function automatic logic [W-1:0] ref_calc(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic [1:0] op);
      longint sa = longint'($signed(a));
      longint sb = longint'($signed(b));
      longint ua = longint'({32'd0, a});
      longint ub = longint'({32'd0, b});
      longint r;
      if (b == 0) return op[1] ? a : 32'hFFFF_FFFF;
      case (op)
         2'd0: r = sa / sb;
         2'd1: r = ua / ub;
         2'd2: r = sa % sb;
         default: r = ua % ub;
      endcase
      return r[W-1:0];
   endfunction

   // driver: push expected item, pulse start, scramble inputs afterwards (R12)
   task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] op,
                        input string req, input bit wait_done);
      bit sp;
      while (busy_o) @(negedge clk);
      sp = is_special(a, b, op);
      dividend_i = a; divisor_i = b; op_i = op; start_i = 1'b1;
      exp_q.push_back(ref_calc(a, b, op));
      lat_q.push_back(sp ? 1 : W + 2);
      iss_q.push_back(cyc);
      req_q.push_back(req);
      @(negedge clk);
      start_i = 1'b0;
      dividend_i = $urandom; divisor_i = $urandom; op_i = ~op;
      check(busy_o == !sp, sp ? "R7 busy stays low" : "R8 busy high after start",
            W'(busy_o), W'(!sp));
      if (wait_done) begin
         while (exp_q.size() != 0) begin
            @(negedge clk);
            dividend_i = $urandom; divisor_i = $urandom;
         end
      end
   endtask

   // monitor: pop and compare on each done (R10 one done per operation)
   always @(negedge clk) begin
      if (!rst) begin
         if (done_o) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9_R10 unexpected done", result_o, '0);
            end else begin
               logic [W-1:0] e;
               int l, s;
               string r;
               e = exp_q.pop_front(); l = lat_q.pop_front();
               s = iss_q.pop_front(); r = req_q.pop_front();
               check(result_o == e, r, result_o, e);
               check((cyc - s) == l, {r, " R7_R8 latency"}, W'(cyc - s), W'(l));
               last_res = result_o;
            end
         end else begin
            check(result_o == last_res, "R10 result hold", result_o, last_res);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog expired", '0, '0);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(done_o == 1'b0, "R11 done in reset", W'(done_o), '0);
      check(busy_o == 1'b0, "R11 busy in reset", W'(busy_o), '0);
      check(result_o == '0, "R11 result in reset", result_o, '0);
      rst = 1'b0;
      @(negedge clk);

      issue(32'h8000_0000, 32'd2, 2'd1, "R1 udiv", 1);
      issue(32'h1234_5678, 32'h10, 2'd3, "R1 urem", 1);
      issue(32'hFFFF_FFFE, 32'd2, 2'd0, "R2 -2/2", 1);
      issue(32'hFFFF_FFF9, 32'd2, 2'd0, "R2 -7/2", 1);
      issue(32'd7, 32'hFFFF_FFFE, 2'd0, "R2 7/-2", 1);
      issue(32'hFFFF_FFFE, 32'd3, 2'd2, "R3 -2 rem 3", 1);
      issue(32'd7, 32'hFFFF_FFFE, 2'd2, "R3 7 rem -2", 1);
      issue(32'hFFFF_FFF9, 32'hFFFF_FFFE, 2'd2, "R3 -7 rem -2", 1);
      issue(32'h1234_5678, 32'd0, 2'd0, "R4 sdiv by zero", 1);
      issue(32'h8000_0000, 32'd0, 2'd1, "R4 udiv by zero", 1);
      issue(32'h89AB_CDEF, 32'd0, 2'd2, "R5 srem by zero", 1);
      issue(32'h1234_5678, 32'd0, 2'd3, "R5 urem by zero", 1);
      issue(32'h8000_0000, 32'hFFFF_FFFF, 2'd0, "R6 overflow quo", 1);
      issue(32'h8000_0000, 32'hFFFF_FFFF, 2'd2, "R6 overflow rem", 1);
      issue(32'h8000_0000, 32'hFFFF_FFFF, 2'd1, "R1 unsigned not overflow", 1);
      issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd3, "R1 urem equal", 1);
      issue(32'd5, 32'd9, 2'd1, "R1 small over big", 1);

      // R9: start while busy, with a zero divisor that would finish at once
      issue(32'd1000, 32'd7, 2'd0, "R9 op in progress", 0);
      repeat (5) @(negedge clk);
      dividend_i = 32'h5555_5555; divisor_i = 32'd0; op_i = 2'd3; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (exp_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
      check(busy_o == 1'b0, "R9 ignored start left no run", W'(busy_o), '0);

      for (int i = 0; i < 48; i++) begin
         logic [W-1:0] a, b;
         a = $urandom;
         b = (i % 3 == 0) ? W'($urandom_range(1, 300)) : W'($urandom);
         if (i % 4 == 1) b = -b;
         issue(a, b, 2'(i % 4), "R1_R2_R3_R12 random", 1);
      end

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R10 all results seen", W'(exp_q.size()), '0);
      summary();
      $finish;
   end

endmodule